// File: doc/BRIEF.md
# Framed Serial Register Port (Device Side)

This block is the device-side serial port of a converter whose serial clock is supplied by the host. The host frames a write with an active-low write frame strobe and a read with an active-low read frame strobe. A register-select line picks the target. With the select line low, a write loads the 24-bit control register. With it high, the write loads one of the 24-bit calibration registers, chosen by a system-side index port.

On reads, select low returns the control register. Select high returns either the latest conversion word or a calibration register, depending on a system-side read-source input. Data moves most significant bit first in both directions.

All host-side lines cross into the system clock through a synchroniser. Serial clock edges are found from the synchronised samples. A frame strobe may go inactive in the middle of a word and come back later; the bit position is kept across the gap.

A conversion result is delivered on a one-cycle strobe, and the active-low ready flag then goes low. The flag returns high once all 24 bits of the conversion word have been read. The serial data output is modelled as a data bit plus an output enable.

Top module: `framed_reg_port`

## Requirements
- R1: After reset, `readyN` is 1, `serDoutEn` is 0 and `ctrlOut` equals `CTRL_RESET` (all zeros by default).
- R2: With `regSel` low during a write frame, the 24 bits sampled on successive `serClk` rising edges (first bit is bit 23) load the control register. `ctrlOut` changes only when the 24th bit has been taken.
- R3: With `regSel` high during a write frame, the 24-bit word loads the calibration register whose index is on `calIdx`, and `ctrlOut` is left unchanged.
- R4: If `wrFrameN` goes high partway through a word, serial clock pulses during the gap are ignored. The bit count is held, and the next bit is taken on the first `serClk` rise after `wrFrameN` is low again.
- R5: Writes never change `readyN`. Only R6 lowers it and only R7 raises it.
- R6: A one-cycle `convValid` pulse captures `convWord` as the output word and drives `readyN` low on the next clock.
- R7: In a read frame with `regSel` high and `calReadSel` low, the output word is presented on `serDout` MSB first, one bit per `serClk` high phase, advancing after each falling edge. After the 24th bit, `readyN` goes high and `serDoutEn` goes low, even while `rdFrameN` stays low.
- R8: In a read frame with `regSel` high and `calReadSel` high, the calibration register at `calIdx` is returned MSB first, and `readyN` keeps its value.
- R9: In a read frame with `regSel` low, the control register is returned MSB first.
- R10: If `rdFrameN` goes high partway through a read, `serDoutEn` is 0 during the gap and serial clock pulses there do not advance the word. The read resumes at the held bit once `rdFrameN` is low again.
- R11: `serDoutEn` is 1 only while the synchronised read frame is low and a read word is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Host serial clock, idles low |
| wrFrameN | input | 1 | Active-low write frame strobe |
| rdFrameN | input | 1 | Active-low read frame strobe |
| regSel | input | 1 | Register select: 0 control, 1 calibration / output word |
| serDin | input | 1 | Serial write data |
| serDout | output | 1 | Serial read data |
| serDoutEn | output | 1 | Output enable of serDout (0 = high impedance) |
| readyN | output | 1 | Active-low conversion word ready flag |
| convValid | input | 1 | One-cycle strobe: new conversion word |
| convWord | input | WORD_W | Conversion word |
| calReadSel | input | 1 | On select-high reads: 0 output word, 1 calibration register |
| calIdx | input | CAL_IDX_W | Calibration register index |
| ctrlOut | output | WORD_W | Current control register |

## Verification
The bench builds the block with its defaults: a 24-bit word, two calibration registers and two synchroniser stages. With these values both calibration slots are written and read back with distinct patterns, and the 1-bit index covers the whole slot range. The short synchroniser keeps edge latency to three system cycles, so a serial clock of ten system cycles per phase exercises mid-word frame gaps in both directions, including ignored clock pulses inside the gaps.

// File: rtl/frp_pkg.sv
package frp_pkg;

  typedef enum logic [1:0] {
    SRC_OUT  = 2'd0,
    SRC_CAL  = 2'd1,
    SRC_CTRL = 2'd2
  } rdSrc_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic   wrShift;
    logic   wrCommit;
    logic   wrToCal;
    logic   rdLoad;
    logic   rdShift;
    logic   rdDone;
    rdSrc_e rdSrc;
  } ctlStrobe_t;

endpackage

// File: rtl/frp_sync.sv
module frp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= RST_VAL;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/frp_ctrl.sv
module frp_ctrl
  import frp_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkS,
  input  logic       wrFrameNS,
  input  logic       rdFrameNS,
  input  logic       regSelS,
  input  logic       calReadSel,
  output ctlStrobe_t st,
  output logic       sdoEn
);

  localparam int CntW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CntW-1:0] LastBit = CntW'(WORD_W - 1);

  logic            sclkPrev;
  logic            sclkRise, sclkFall;
  logic [CntW-1:0] wrCnt, rdCnt;
  logic            rdBusy, rdHold;
  rdSrc_e          srcQ, srcNew;
  logic            wrStep, wrLast, rdStart, rdStep, rdLast;

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;

  always_comb begin
    if (!regSelS)        srcNew = SRC_CTRL;
    else if (calReadSel) srcNew = SRC_CAL;
    else                 srcNew = SRC_OUT;
  end

  assign wrStep  = sclkRise & ~wrFrameNS;
  assign wrLast  = (wrCnt == LastBit);
  assign rdStart = ~rdFrameNS & ~rdBusy & ~rdHold;
  assign rdStep  = sclkFall & ~rdFrameNS & rdBusy;
  assign rdLast  = (rdCnt == LastBit);

  always_comb begin
    st.wrShift  = wrStep;
    st.wrCommit = wrStep & wrLast;
    st.wrToCal  = regSelS;
    st.rdLoad   = rdStart;
    st.rdShift  = rdStep & ~rdLast;
    st.rdDone   = rdStep & rdLast;
    st.rdSrc    = rdStart ? srcNew : srcQ;
  end

  assign sdoEn = rdBusy & ~rdFrameNS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
    end
  end

  // Write bit counter: held while the write frame is inactive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt <= '0;
    end else if (wrStep) begin
      wrCnt <= wrLast ? '0 : wrCnt + 1'b1;
    end
  end

  // Read sequencing: busy across frame gaps, hold after completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCnt  <= '0;
      rdBusy <= 1'b0;
      rdHold <= 1'b0;
      srcQ   <= SRC_OUT;
    end else begin
      if (rdFrameNS) rdHold <= 1'b0;
      if (rdStart) begin
        rdBusy <= 1'b1;
        rdCnt  <= '0;
        srcQ   <= srcNew;
      end else if (rdStep) begin
        if (rdLast) begin
          rdBusy <= 1'b0;
          rdHold <= 1'b1;
          rdCnt  <= '0;
        end else begin
          rdCnt <= rdCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/frp_datapath.sv
module frp_datapath
  import frp_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int NUM_CAL = 2,
  parameter int CAL_IDX_W = 1,
  parameter logic [WORD_W-1:0] CTRL_RESET = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           st,
  input  logic                 sdiS,
  input  logic [CAL_IDX_W-1:0] calIdx,
  input  logic                 convValid,
  input  logic [WORD_W-1:0]    convWord,
  output logic [WORD_W-1:0]    ctrlOut,
  output logic                 sdoBit,
  output logic                 readyN
);

  logic [WORD_W-1:0]         wrShiftQ, wrNext, ctrlQ, outWordQ, rdShiftQ, calWord;
  logic [NUM_CAL*WORD_W-1:0] calFlat;
  logic                      readyNQ;

  assign wrNext = {wrShiftQ[WORD_W-2:0], sdiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           wrShiftQ <= '0;
    else if (st.wrShift) wrShiftQ <= wrNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           ctrlQ <= CTRL_RESET;
    else if (st.wrCommit && !st.wrToCal) ctrlQ <= wrNext;
  end

  for (genvar i = 0; i < NUM_CAL; i++) begin : g_cal
    logic [WORD_W-1:0] calQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) calQ <= '0;
      else if (st.wrCommit && st.wrToCal && calIdx == CAL_IDX_W'(i)) calQ <= wrNext;
    end
    assign calFlat[i*WORD_W +: WORD_W] = calQ;
  end

  always_comb begin
    calWord = '0;
    for (int i = 0; i < NUM_CAL; i++) begin
      if (calIdx == CAL_IDX_W'(i)) calWord = calFlat[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShiftQ <= '0;
    end else if (st.rdLoad) begin
      case (st.rdSrc)
        SRC_OUT: rdShiftQ <= outWordQ;
        SRC_CAL: rdShiftQ <= calWord;
        default: rdShiftQ <= ctrlQ;
      endcase
    end else if (st.rdShift) begin
      rdShiftQ <= {rdShiftQ[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWordQ <= '0;
      readyNQ  <= 1'b1;
    end else if (convValid) begin
      outWordQ <= convWord;
      readyNQ  <= 1'b0;
    end else if (st.rdDone && st.rdSrc == SRC_OUT) begin
      readyNQ <= 1'b1;
    end
  end

  assign ctrlOut = ctrlQ;
  assign sdoBit  = rdShiftQ[WORD_W-1];
  assign readyN  = readyNQ;

endmodule

// File: rtl/framed_reg_port.sv
module framed_reg_port
  import frp_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int NUM_CAL = 2,
  parameter int CAL_IDX_W = (NUM_CAL > 1) ? $clog2(NUM_CAL) : 1,
  parameter int SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] CTRL_RESET = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 wrFrameN,
  input  logic                 rdFrameN,
  input  logic                 regSel,
  input  logic                 serDin,
  output logic                 serDout,
  output logic                 serDoutEn,
  output logic                 readyN,
  input  logic                 convValid,
  input  logic [WORD_W-1:0]    convWord,
  input  logic                 calReadSel,
  input  logic [CAL_IDX_W-1:0] calIdx,
  output logic [WORD_W-1:0]    ctrlOut
);

  localparam int NumLines = 5;
  localparam logic [NumLines-1:0] LineRst = 5'b0_1_1_0_0;

  logic [NumLines-1:0] linesS;
  logic                sclkS, wrFrameNS, rdFrameNS, regSelS, serDinS;
  ctlStrobe_t          st;

  frp_sync #(
    .WIDTH  (NumLines),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LineRst)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({serClk, wrFrameN, rdFrameN, regSel, serDin}),
    .dout(linesS)
  );

  assign {sclkS, wrFrameNS, rdFrameNS, regSelS, serDinS} = linesS;

  frp_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclkS     (sclkS),
    .wrFrameNS (wrFrameNS),
    .rdFrameNS (rdFrameNS),
    .regSelS   (regSelS),
    .calReadSel(calReadSel),
    .st        (st),
    .sdoEn     (serDoutEn)
  );

  frp_datapath #(
    .WORD_W    (WORD_W),
    .NUM_CAL   (NUM_CAL),
    .CAL_IDX_W (CAL_IDX_W),
    .CTRL_RESET(CTRL_RESET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .sdiS     (serDinS),
    .calIdx   (calIdx),
    .convValid(convValid),
    .convWord (convWord),
    .ctrlOut  (ctrlOut),
    .sdoBit   (serDout),
    .readyN   (readyN)
  );

endmodule

// File: rtl/frp_checker.sv
module frp_checker
  import frp_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              readyN,
  input logic              serDoutEn,
  input logic              rdFrameNS,
  input logic              convValid,
  input logic [WORD_W-1:0] ctrlOut,
  input ctlStrobe_t        st
);

  a_r6_ready_low_after_conv: assert property (@(posedge clk) disable iff (!rstN)
    convValid |=> !readyN);

  a_r5_ready_fall_only_conv: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> $past(convValid));

  a_r7_ready_rise_on_word_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyN) |-> $past(st.rdDone && st.rdSrc == SRC_OUT));

  a_r7_release_after_last_bit: assert property (@(posedge clk) disable iff (!rstN)
    st.rdDone |=> !serDoutEn);

  a_r11_drive_only_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    serDoutEn |-> !rdFrameNS);

  a_r2_ctrl_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrCommit && !st.wrToCal) |=> $stable(ctrlOut));

endmodule

bind framed_reg_port frp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .readyN   (readyN),
  .serDoutEn(serDoutEn),
  .rdFrameNS(rdFrameNS),
  .convValid(convValid),
  .ctrlOut  (ctrlOut),
  .st       (st)
);

// File: tb/tb_framed_reg_port.sv
`timescale 1ns/1ps
module tb_framed_reg_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        wrFrameN = 1'b1;
  logic        rdFrameN = 1'b1;
  logic        regSel = 1'b0;
  logic        serDin = 1'b0;
  logic        serDout, serDoutEn, readyN;
  logic        convValid = 1'b0;
  logic [23:0] convWord = '0;
  logic        calReadSel = 1'b0;
  logic [0:0]  calIdx = '0;
  logic [23:0] ctrlOut;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  logic [23:0] expQ[$];
  string       tagQ[$];
  bit          monActive = 0;
  logic [23:0] acc = '0;
  int          nBits = 0;

  always #2 clk = ~clk;

  framed_reg_port dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .wrFrameN(wrFrameN),
    .rdFrameN(rdFrameN), .regSel(regSel), .serDin(serDin),
    .serDout(serDout), .serDoutEn(serDoutEn), .readyN(readyN),
    .convValid(convValid), .convWord(convWord), .calReadSel(calReadSel),
    .calIdx(calIdx), .ctrlOut(ctrlOut)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: collects read bits while serClk is high, compares with scoreboard
  initial begin
    forever begin
      @(posedge serClk);
      if (monActive && !rdFrameN) begin
        #20;
        if (!serDoutEn) check(1'b0, "R11 enable during read bit", 24'(serDoutEn), 24'd1);
        acc = {acc[22:0], serDout};
        nBits++;
        if (nBits == 24) begin
          logic [23:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(acc == e, t, acc, e);
          nBits = 0;
        end
      end
    end
  end

  task automatic sclkPulse();
    serClk = 1'b1; #40;
    serClk = 1'b0; #40;
  endtask

  task automatic hostWrite(input logic sel, input logic [23:0] w,
                           input int pauseAfter, input logic [23:0] ctrlHold);
    regSel = sel; #8;
    wrFrameN = 1'b0; #8;
    for (int i = 23; i >= 0; i--) begin
      serDin = w[i]; #8;
      serClk = 1'b1; #40;
      serClk = 1'b0; #32;
      if (23 - i == pauseAfter) begin
        wrFrameN = 1'b1; #40;
        serDin = 1'b1;
        sclkPulse();
        sclkPulse();
        // R4: partial word plus ignored pulses must not reach the register
        check(ctrlOut == ctrlHold, "R4 ctrl during write gap", ctrlOut, ctrlHold);
        wrFrameN = 1'b0; #40;
      end
    end
    wrFrameN = 1'b1; #96;
  endtask

  task automatic hostRead(input logic sel, input logic calRd, input logic idx,
                          input logic [23:0] exp, input string tag, input int pauseAfter);
    regSel = sel; calReadSel = calRd; calIdx = idx;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    #8;
    rdFrameN = 1'b0; monActive = 1; #40;
    for (int i = 0; i < 24; i++) begin
      sclkPulse();
      if (i == pauseAfter) begin
        rdFrameN = 1'b1; #40;
        check(serDoutEn == 1'b0, "R10 enable off in read gap", 24'(serDoutEn), 24'd0);
        sclkPulse();
        sclkPulse();
        rdFrameN = 1'b0; #40;
      end
    end
    #40;
    check(serDoutEn == 1'b0, "R7 released after last bit", 24'(serDoutEn), 24'd0);
    monActive = 0;
    rdFrameN = 1'b1; #96;
  endtask

  task automatic convPulse(input logic [23:0] w);
    @(negedge clk);
    convWord = w; convValid = 1'b1;
    @(negedge clk);
    convValid = 1'b0;
    #16;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(readyN == 1'b1, "R1 readyN after reset", 24'(readyN), 24'd1);
    check(serDoutEn == 1'b0, "R1 enable after reset", 24'(serDoutEn), 24'd0);
    check(ctrlOut == 24'h0, "R1 ctrl after reset", ctrlOut, 24'h0);

    // R2 control write, no gap
    hostWrite(1'b0, 24'hA5C317, -1, 24'h0);
    check(ctrlOut == 24'hA5C317, "R2 ctrl write", ctrlOut, 24'hA5C317);

    // R4 control write with gap after 12 bits (holds old value during gap)
    hostWrite(1'b0, 24'h5A0F69, 11, 24'hA5C317);
    check(ctrlOut == 24'h5A0F69, "R4 ctrl after resumed write", ctrlOut, 24'h5A0F69);

    // R2 gap after 23 bits: last bit still outstanding
    hostWrite(1'b0, 24'h00FF01, 22, 24'h5A0F69);
    check(ctrlOut == 24'h00FF01, "R2 ctrl after late gap", ctrlOut, 24'h00FF01);

    // R3 calibration writes leave control unchanged
    calIdx = 1'b0;
    hostWrite(1'b1, 24'h123456, -1, 24'h00FF01);
    calIdx = 1'b1;
    hostWrite(1'b1, 24'hFEDCBA, -1, 24'h00FF01);
    check(ctrlOut == 24'h00FF01, "R3 ctrl after cal writes", ctrlOut, 24'h00FF01);

    // R9 control readback, R8/R3 calibration readback
    hostRead(1'b0, 1'b0, 1'b0, 24'h00FF01, "R9 ctrl read", -1);
    hostRead(1'b1, 1'b1, 1'b1, 24'hFEDCBA, "R8 R3 cal1 read", -1);
    hostRead(1'b1, 1'b1, 1'b0, 24'h123456, "R8 R3 cal0 read", -1);
    check(readyN == 1'b1, "R8 ready unchanged by cal read", 24'(readyN), 24'd1);

    // R6 conversion word arrives
    convPulse(24'h800001);
    check(readyN == 1'b0, "R6 readyN low after conv", 24'(readyN), 24'd0);

    // R5 write does not touch ready
    hostWrite(1'b0, 24'h3C00C3, -1, 24'h00FF01);
    check(readyN == 1'b0, "R5 readyN after write", 24'(readyN), 24'd0);
    check(ctrlOut == 24'h3C00C3, "R2 ctrl second write", ctrlOut, 24'h3C00C3);

    // R8 calibration read while word pending keeps ready low
    hostRead(1'b1, 1'b1, 1'b0, 24'h123456, "R8 cal read pending", -1);
    check(readyN == 1'b0, "R8 readyN held low", 24'(readyN), 24'd0);

    // R7 output word read
    hostRead(1'b1, 1'b0, 1'b0, 24'h800001, "R7 output word read", -1);
    check(readyN == 1'b1, "R7 readyN high after read", 24'(readyN), 24'd1);

    // R10 read with a frame gap after 10 bits
    convPulse(24'h3C5AA6);
    check(readyN == 1'b0, "R6 readyN low second conv", 24'(readyN), 24'd0);
    hostRead(1'b1, 1'b0, 1'b0, 24'h3C5AA6, "R10 output word with gap", 9);
    check(readyN == 1'b1, "R7 readyN high after gapped read", 24'(readyN), 24'd1);

    // R9 control read with gap
    hostRead(1'b0, 1'b0, 1'b0, 24'h3C00C3, "R10 R9 ctrl read with gap", 16);

    check(expQ.size() == 0, "R7 scoreboard drained", 24'(expQ.size()), 24'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule